// File: doc/BRIEF.md
# Prescaled Supervisory Watchdog

This block watches over software that is expected to check in at regular intervals. The system clock is first divided down to a machine-cycle rate. That rate goes through a programmable power-of-two prescaler and then drives a wide up-counter. If software does not restart the chain before the counter rolls over, the block raises a reset request. The request lasts exactly one machine cycle, and the counter starts again from zero.

Software controls the block through one byte-wide control register. The register has an enable flag and a restart flag that clears itself. It also has a flag that decides whether counting goes on while the host is idle, and a three-bit divisor select. An idle indication from the power controller pauses the chain unless the idle-run flag is set. Distributing the reset request to the rest of the chip is left to the surrounding logic.

Top module: `wdt_supervisor`

## Requirements
- R1: After synchronous reset the control register reads 0x00, the reset request output is low, and all dividers and the counter start from zero.
- R2: The control register answers at address CTRL_ADDR (default 0x8F). Bit 7 is enable, bit 6 is restart, bit 5 is idle-run, bits 4:3 always read 0, and bits 2:0 are the divisor select. A read returns data on rd_data one clock after rd_en is sampled. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: Divisor select code s sets the prescaler ratio to 2^(s+1), which covers 2 to 256.
- R4: Let a write with enable=1 and restart=1 be captured on clock edge E. Let L = MC_DIV × 2^(s+1) × 2^COUNT_W. The reset request then rises on edge E+1+L if nothing else intervenes.
- R5: The reset request stays high for exactly MC_DIV clocks. The counter wraps to zero, and the next request rises L clocks after the previous one.
- R6: A written restart bit reads back as 1 for one cycle and as 0 from then on. On the clock after the write it clears the machine-cycle divider, the prescaler and the counter. Restarting more often than every L clocks keeps the request low.
- R7: While enable is 0, nothing advances and no request is raised. Progress already made is kept and resumes when enable is set again.
- R8: With idle-run at 0, every clock that samples idle_i high is left out of the count, so the timeout is delayed by exactly that many clocks.
- R9: With idle-run at 1, idle_i has no effect on the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| idle_i | input | 1 | Host idle indication |
| wdt_rst_o | output | 1 | Reset request, one machine cycle wide |

## Verification
The bench measures the timeout to the exact clock edge for three divisor codes. A chain that drops or adds a register stage, or gets the select-to-ratio mapping wrong, lands on the wrong cycle. The bench also checks the request width and the spacing between two requests. A counter that fails to wrap, or a pulse stretcher that is off by one, would show up there. The bench pauses the count in two ways, through the enable flag and through the idle input, and then checks that counting resumes from where it stopped. A design that cleared its progress on disable, or ignored the idle-run flag, would fire early or late. The restart bit is read back on the cycle right after it is written, which catches a bit that never clears or clears too late.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic       enw;
    logic       clr;
    logic       idle_run;
    logic [1:0] rsv;
    logic [2:0] sel;
  } wdt_ctrl_t;

  localparam logic [7:0] CTRL_WMASK = 8'b1110_0111;

  // terminal count of the prescaler for select code s: 2^(s+1) - 1
  function automatic logic [7:0] sel_to_limit(input logic [2:0] s);
    return 8'hFF >> (3'd7 - s);
  endfunction

endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              enw_o,
  output logic              clr_o,
  output logic              idle_run_o,
  output logic [2:0]        sel_o
);

  wdt_ctrl_t ctrl_q;
  logic      wr_hit;
  logic      rd_hit;

  assign wr_hit = wr_en && (wr_addr == CTRL_ADDR);
  assign rd_hit = rd_en && (rd_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_hit) begin
      ctrl_q <= wdt_ctrl_t'(wr_data & CTRL_WMASK);
    end else if (ctrl_q.clr) begin
      ctrl_q.clr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_hit ? 8'(ctrl_q) : 8'h00;
    end
  end

  assign enw_o      = ctrl_q.enw;
  assign clr_o      = ctrl_q.clr;
  assign idle_run_o = ctrl_q.idle_run;
  assign sel_o      = ctrl_q.sel;

endmodule

// File: rtl/wdt_div.sv
module wdt_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;

  assign tick_o = adv && !clr && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= tick_o ? '0 : cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic         ovf_o,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  assign ovf_o = adv && !clr && (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);

  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      left_q  <= '0;
    end else if (fire) begin
      pulse_o <= 1'b1;
      left_q  <= LW'(LEN - 1);
    end else if (left_q != '0) begin
      left_q  <= left_q - LW'(1);
    end else begin
      pulse_o <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F,
  parameter int MC_DIV  = 12,
  parameter int COUNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              idle_i,
  output logic              wdt_rst_o
);

  localparam int MC_W = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
  localparam logic [MC_W-1:0] MC_LIM = MC_W'(MC_DIV - 1);

  logic               enw;
  logic               clr;
  logic               idle_run;
  logic [2:0]         sel;
  logic               run;
  logic               mc_tick;
  logic               pre_tick;
  logic               ovf;
  logic [COUNT_W-1:0] cnt;

  wdt_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .enw_o(enw), .clr_o(clr), .idle_run_o(idle_run), .sel_o(sel)
  );

  assign run = enw && (!idle_i || idle_run);

  wdt_div #(.W(MC_W)) u_mcdiv (
    .clk(clk), .rst(rst), .clr(clr), .adv(run),
    .limit(MC_LIM), .tick_o(mc_tick)
  );

  wdt_div #(.W(8)) u_presc (
    .clk(clk), .rst(rst), .clr(clr), .adv(mc_tick),
    .limit(sel_to_limit(sel)), .tick_o(pre_tick)
  );

  wdt_count #(.W(COUNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(clr), .adv(pre_tick),
    .ovf_o(ovf), .cnt_o(cnt)
  );

  wdt_pulse #(.LEN(MC_DIV)) u_pulse (
    .clk(clk), .rst(rst), .fire(ovf), .pulse_o(wdt_rst_o)
  );

endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int MC_DIV  = 12,
  parameter int COUNT_W = 14
) (
  input logic               clk,
  input logic               rst,
  input logic               pulse,
  input logic               enw,
  input logic               clr,
  input logic               idle,
  input logic               idle_run,
  input logic [COUNT_W-1:0] cnt,
  input logic [7:0]         rd_data
);

  localparam int HW = $clog2(MC_DIV + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (pulse) hi_cnt <= hi_cnt + HW'(1);
    else hi_cnt <= '0;
  end

  assert_pulse_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(enw));

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse) |-> (hi_cnt == HW'(MC_DIV)));

  assert_pulse_max_R5: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= HW'(MC_DIV));

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!enw && !clr) |=> $stable(cnt));

  assert_idle_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (idle && !idle_run && !clr) |=> $stable(cnt));

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[4:3] == 2'b00);

endmodule

bind wdt_supervisor wdt_supervisor_chk #(.MC_DIV(MC_DIV), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .pulse(wdt_rst_o), .enw(enw), .clr(clr),
  .idle(idle_i), .idle_run(idle_run), .cnt(cnt), .rd_data(rd_data)
);

// File: tb/sim_wdt_supervisor.sv
module sim_wdt_supervisor;

  localparam int MC  = 12;
  localparam int CW  = 4;
  localparam int CNT = 1 << CW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       idle_i = 1'b0;
  logic       wdt_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mark = 0;

  wdt_supervisor #(.MC_DIV(MC), .COUNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .idle_i(idle_i), .wdt_rst_o(wdt_rst_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(input int s);
    return MC * (2 << s) * CNT;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write captured on the next edge; returns at the negedge after it
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mark = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  // edges from the mark until the request is seen high; -1 if not within lim
  task automatic wait_rise(input int lim, output int d);
    d = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (wdt_rst_o) begin
        d = cyc - mark;
        break;
      end
    end
  endtask

  task automatic quiesce();
    wr(8'h8F, 8'h00);
    while (wdt_rst_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 request low after reset", int'(wdt_rst_o), 0);
    rd(8'h8F, v);
    chk("R1 register after reset", int'(v), 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h8F; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; rd_addr = 8'h8F;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 restart bit visible one cycle", int'(rd_data), 8'hE7);
    rd(8'h8F, v);
    chk("R2 R6 fields after restart clears", int'(v), 8'hA7);
    wr(8'h8E, 8'h00);
    rd(8'h8F, v);
    chk("R2 foreign write ignored", int'(v), 8'hA7);
    rd(8'h8E, v);
    chk("R2 foreign read zero", int'(v), 0);
    quiesce();
  endtask

  task automatic t_timeout(input int s);
    int d;
    wr(8'h8F, 8'hC0 | 8'(s));
    wait_rise(period(s) + 100, d);
    chk($sformatf("R3 R4 timeout sel %0d", s), d, 1 + period(s));
    quiesce();
  endtask

  task automatic t_pulse_wrap();
    int d;
    int w;
    wr(8'h8F, 8'hC0);
    wait_rise(period(0) + 100, d);
    chk("R4 first timeout", d, 1 + period(0));
    mark = cyc;
    w = 0;
    while (wdt_rst_o && w < 100) begin
      w++;
      @(negedge clk);
    end
    chk("R5 pulse width", w, MC);
    mark = mark - 0;
    begin
      int m0;
      m0 = mark;
      wait_rise(period(0) + 100, d);
      chk("R5 wrap period", cyc - m0, period(0));
    end
    quiesce();
  endtask

  task automatic t_periodic_clear();
    int d;
    int seen;
    seen = 0;
    wr(8'h8F, 8'hC0);
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (wdt_rst_o) seen = 1;
      end
      wr(8'h8F, 8'hC0);
    end
    chk("R6 periodic restart keeps request low", seen, 0);
    wait_rise(period(0) + 100, d);
    chk("R6 timeout from last restart", d, 1 + period(0));
    quiesce();
  endtask

  task automatic t_disable();
    int a, b, c, d, seen;
    seen = 0;
    wr(8'h8F, 8'hC0); a = mark;
    repeat (100) @(negedge clk);
    wr(8'h8F, 8'h00); b = mark;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (wdt_rst_o) seen = 1;
    end
    chk("R7 no request while disabled", seen, 0);
    wr(8'h8F, 8'h80); c = mark;
    wait_rise(period(0) + 100, d);
    chk("R7 progress kept across disable", d, period(0) - (b - a - 1));
    quiesce();
  endtask

  task automatic t_idle(input logic run_idle);
    int d;
    wr(8'h8F, run_idle ? 8'hE0 : 8'hC0);
    repeat (50) @(negedge clk);
    idle_i = 1'b1;
    repeat (300) @(negedge clk);
    idle_i = 1'b0;
    wait_rise(period(0) + 400, d);
    if (run_idle) chk("R9 idle ignored with idle-run", d, 1 + period(0));
    else          chk("R8 idle delays timeout", d, 1 + period(0) + 300);
    quiesce();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_timeout(0);
    t_timeout(3);
    t_timeout(7);
    t_pulse_wrap();
    t_periodic_clear();
    t_disable();
    t_idle(1'b0);
    t_idle(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule